// File: doc/BRIEF.md
# Single-Cycle Datapath Control Decoder

This block is the control decoder of a 32-bit processor that finishes one instruction per clock. It takes the opcode, the two register-specifier fields, the branch decision, the two memory error flags and the datapath words (constant, operand A, ALU result, memory read value, fall-through PC). From these it chooses the register-file read and write port addresses, the data-memory enables, the data-memory address and write data, the next program counter and the instruction status. Stack instructions address the stack-pointer register without naming it in the instruction. The next PC comes from the constant, the memory read value or the fall-through address, depending on the opcode.

The register file, the memories and the ALU sit outside the block. All of the selection is combinational and is captured into output registers, so each decision appears one clock after its inputs. Opcodes are 4 bits wide: 0 halt, 1 no-op, 2 register move, 3 immediate move, 4 register-to-memory move, 5 memory-to-register move, 6 ALU operation, 7 conditional jump, 8 call, 9 return, 10 push, 11 pop. Codes 12 to 15 are invalid. Register ID 4 is the stack pointer and register ID 8 means no access.

Top module: `ctl_decoder`

## Requirements
- R1: While the synchronous active-high reset is held, every register port reads 8, both memory enables read 0, the address, write-data and next-PC words read 0, and the status reads 1 (OK). Outside reset, every output shows the decision for the inputs presented one clock earlier.
- R2: Read address A is rA for register move, register-to-memory move, ALU operation and push. It is 4 for pop and return, and 8 for every other opcode.
- R3: Read address B is rB for ALU operation, register-to-memory move and memory-to-register move. It is 4 for push, pop, call and return, and 8 otherwise.
- R4: Write address E is rB for register move, immediate move and ALU operation. It is 4 for push, pop, call and return, and 8 otherwise.
- R5: Write address M is rA for memory-to-register move and pop, and 8 otherwise.
- R6: The memory read enable is 1 exactly for memory-to-register move, pop and return.
- R7: The memory write enable is 1 for register-to-memory move, push and call. The write data is the fall-through PC for call and operand A for the other two.
- R8: The memory address is the ALU result for register-to-memory move, push, call and memory-to-register move. It is operand A for pop and return, and 0 for every other opcode.
- R9: The next PC is the constant for call and for a jump with the branch flag set. It is the memory read value for return, and the fall-through PC otherwise, including a jump with the branch flag clear.
- R10: The status is 3 (address error) if either memory error flag is set. Failing that, it is 4 (invalid instruction) for opcodes 12 to 15, then 2 (halt) for opcode 0, and 1 (OK) otherwise.
- R11: When the status is not OK, both write addresses read 8 and the memory write enable reads 0.
- R12: When the instruction-memory error flag is set, the opcode is treated as a no-op. No memory access happens, the register ports read 8, and the next PC is the fall-through PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icode_i | input | 4 | Opcode |
| ra_i | input | 4 | First register field |
| rb_i | input | 4 | Second register field |
| bch_i | input | 1 | Branch condition met |
| imem_err_i | input | 1 | Instruction memory error |
| dmem_err_i | input | 1 | Data memory error |
| valc_i | input | 32 | Instruction constant |
| vala_i | input | 32 | Operand A value |
| vale_i | input | 32 | ALU result |
| valm_i | input | 32 | Memory read value |
| valp_i | input | 32 | Fall-through PC |
| src_a_o | output | 4 | Read port A address |
| src_b_o | output | 4 | Read port B address |
| dst_e_o | output | 4 | Write port E address |
| dst_m_o | output | 4 | Write port M address |
| mem_rd_o | output | 1 | Data memory read enable |
| mem_wr_o | output | 1 | Data memory write enable |
| mem_addr_o | output | 32 | Data memory address |
| mem_wdata_o | output | 32 | Data memory write data |
| next_pc_o | output | 32 | Next program counter |
| status_o | output | 3 | Instruction status |

## Verification
The block holds no state beyond its output registers. A wrong decision therefore shows at the ports exactly one clock after the instruction that caused it, and it is gone again on the following instruction. A wrong selection shows as a register port reading 8 where a register was expected, as the stack pointer ID in place of a named register, or as a wrong word on the address, data or next-PC outputs. A wrong status priority shows as a write enable or write address that stays active during an error.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  typedef enum logic [3:0] {
    OP_HALT  = 4'h0,
    OP_NOP   = 4'h1,
    OP_RRMOV = 4'h2,
    OP_IRMOV = 4'h3,
    OP_RMMOV = 4'h4,
    OP_MRMOV = 4'h5,
    OP_ALU   = 4'h6,
    OP_JMP   = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB,
    OP_BADC  = 4'hC,
    OP_BADD  = 4'hD,
    OP_BADE  = 4'hE,
    OP_BADF  = 4'hF
  } op_e;

  typedef enum logic [2:0] {
    ST_NONE = 3'd0,
    ST_AOK  = 3'd1,
    ST_HLT  = 3'd2,
    ST_ADR  = 3'd3,
    ST_INS  = 3'd4
  } stat_e;

  localparam logic [3:0] LAST_VALID_OP = 4'hB;
endpackage

// File: rtl/ctl_regsel.sv
module ctl_regsel
  import ctl_pkg::*;
#(
  parameter int RW      = 4,
  parameter int SP_ID   = 4,
  parameter int NONE_ID = 8
) (
  input  op_e           op,
  input  logic [RW-1:0] ra,
  input  logic [RW-1:0] rb,
  input  logic          ok,
  output logic [RW-1:0] src_a,
  output logic [RW-1:0] src_b,
  output logic [RW-1:0] dst_e,
  output logic [RW-1:0] dst_m
);
  localparam logic [RW-1:0] SP   = RW'(SP_ID);
  localparam logic [RW-1:0] NONE = RW'(NONE_ID);

  always_comb begin
    unique case (op)
      OP_RRMOV, OP_RMMOV, OP_ALU, OP_PUSH: src_a = ra;
      OP_POP, OP_RET:                      src_a = SP;
      default:                             src_a = NONE;
    endcase

    unique case (op)
      OP_ALU, OP_RMMOV, OP_MRMOV:          src_b = rb;
      OP_PUSH, OP_POP, OP_CALL, OP_RET:    src_b = SP;
      default:                             src_b = NONE;
    endcase

    unique case (op)
      OP_RRMOV, OP_IRMOV, OP_ALU:          dst_e = rb;
      OP_PUSH, OP_POP, OP_CALL, OP_RET:    dst_e = SP;
      default:                             dst_e = NONE;
    endcase

    unique case (op)
      OP_MRMOV, OP_POP:                    dst_m = ra;
      default:                             dst_m = NONE;
    endcase

    if (!ok) begin
      dst_e = NONE;
      dst_m = NONE;
    end
  end
endmodule

// File: rtl/ctl_memsel.sv
module ctl_memsel
  import ctl_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic         ok,
  input  logic [W-1:0] vala,
  input  logic [W-1:0] vale,
  input  logic [W-1:0] valp,
  output logic         rd,
  output logic         wr,
  output logic [W-1:0] addr,
  output logic [W-1:0] wdata
);
  logic wr_raw;

  always_comb begin
    rd     = (op == OP_MRMOV) || (op == OP_POP) || (op == OP_RET);
    wr_raw = (op == OP_RMMOV) || (op == OP_PUSH) || (op == OP_CALL);
    wr     = wr_raw && ok;
    wdata  = (op == OP_CALL) ? valp : vala;
    unique case (op)
      OP_RMMOV, OP_PUSH, OP_CALL, OP_MRMOV: addr = vale;
      OP_POP, OP_RET:                       addr = vala;
      default:                              addr = '0;
    endcase
  end
endmodule

// File: rtl/ctl_pcstat.sv
module ctl_pcstat
  import ctl_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic         bch,
  input  logic         imem_err,
  input  logic         dmem_err,
  input  logic [W-1:0] valc,
  input  logic [W-1:0] valm,
  input  logic [W-1:0] valp,
  output logic [W-1:0] next_pc,
  output stat_e        status,
  output logic         ok
);
  logic valid;

  always_comb begin
    valid = (op <= LAST_VALID_OP);

    if (op == OP_CALL)             next_pc = valc;
    else if (op == OP_JMP && bch)  next_pc = valc;
    else if (op == OP_RET)         next_pc = valm;
    else                           next_pc = valp;

    if (imem_err || dmem_err)      status = ST_ADR;
    else if (!valid)               status = ST_INS;
    else if (op == OP_HALT)        status = ST_HLT;
    else                           status = ST_AOK;

    ok = (status == ST_AOK);
  end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
#(
  parameter int W       = 32,
  parameter int RW      = 4,
  parameter int SP_ID   = 4,
  parameter int NONE_ID = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    icode_i,
  input  logic [RW-1:0] ra_i,
  input  logic [RW-1:0] rb_i,
  input  logic          bch_i,
  input  logic          imem_err_i,
  input  logic          dmem_err_i,
  input  logic [W-1:0]  valc_i,
  input  logic [W-1:0]  vala_i,
  input  logic [W-1:0]  vale_i,
  input  logic [W-1:0]  valm_i,
  input  logic [W-1:0]  valp_i,
  output logic [RW-1:0] src_a_o,
  output logic [RW-1:0] src_b_o,
  output logic [RW-1:0] dst_e_o,
  output logic [RW-1:0] dst_m_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [W-1:0]  mem_addr_o,
  output logic [W-1:0]  mem_wdata_o,
  output logic [W-1:0]  next_pc_o,
  output logic [2:0]    status_o
);
  localparam logic [RW-1:0] NONE = RW'(NONE_ID);

  op_e           op;
  logic          ok;
  stat_e         st_c;
  logic [W-1:0]  npc_c, addr_c, wdata_c;
  logic          rd_c, wr_c;
  logic [RW-1:0] sa_c, sb_c, de_c, dm_c;

  // a fetch fault turns the instruction into a no-op
  assign op = imem_err_i ? OP_NOP : op_e'(icode_i);

  ctl_pcstat #(.W(W)) u_pcstat (
    .op(op), .bch(bch_i), .imem_err(imem_err_i), .dmem_err(dmem_err_i),
    .valc(valc_i), .valm(valm_i), .valp(valp_i),
    .next_pc(npc_c), .status(st_c), .ok(ok)
  );

  ctl_regsel #(.RW(RW), .SP_ID(SP_ID), .NONE_ID(NONE_ID)) u_regsel (
    .op(op), .ra(ra_i), .rb(rb_i), .ok(ok),
    .src_a(sa_c), .src_b(sb_c), .dst_e(de_c), .dst_m(dm_c)
  );

  ctl_memsel #(.W(W)) u_memsel (
    .op(op), .ok(ok), .vala(vala_i), .vale(vale_i), .valp(valp_i),
    .rd(rd_c), .wr(wr_c), .addr(addr_c), .wdata(wdata_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_a_o     <= NONE;
      src_b_o     <= NONE;
      dst_e_o     <= NONE;
      dst_m_o     <= NONE;
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      next_pc_o   <= '0;
      status_o    <= ST_AOK;
    end else begin
      src_a_o     <= sa_c;
      src_b_o     <= sb_c;
      dst_e_o     <= de_c;
      dst_m_o     <= dm_c;
      mem_rd_o    <= rd_c;
      mem_wr_o    <= wr_c;
      mem_addr_o  <= addr_c;
      mem_wdata_o <= wdata_c;
      next_pc_o   <= npc_c;
      status_o    <= st_c;
    end
  end

  // R11
  wr_needs_ok_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> status_o == ST_AOK);

  // R11
  dst_needs_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o != ST_AOK) |-> (dst_e_o == NONE && dst_m_o == NONE));

  // R6 R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  // R10
  err_to_adr_chk: assert property (@(posedge clk) disable iff (rst)
    (imem_err_i || dmem_err_i) |=> status_o == ST_ADR);

  // R9
  ret_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (icode_i == OP_RET && !imem_err_i) |=> next_pc_o == $past(valm_i));

  // R12
  fetch_fault_nop_chk: assert property (@(posedge clk) disable iff (rst)
    imem_err_i |=> (!mem_rd_o && !mem_wr_o && next_pc_o == $past(valp_i)));
endmodule

// File: tb/tb_ctl_decoder.sv
`timescale 1ns/1ps
module tb_ctl_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  icode = 4'h8, ra = 4'h0, rb = 4'h0;
  logic        bch = 1'b0, ie = 1'b0, de = 1'b0;
  logic [31:0] valc = 32'h0000_0200, vala = 32'h0000_0100, vale = 32'h0000_0300;
  logic [31:0] valm = 32'h0000_0400, valp = 32'h0000_0500;
  logic [3:0]  sa, sb, dse, dsm;
  logic        rd, wr;
  logic [31:0] addr, wdata, npc;
  logic [2:0]  st;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [31:0] VC = 32'h200, VA = 32'h100, VE = 32'h300, VM = 32'h400, VP = 32'h500;

  always #5 clk = ~clk;

  ctl_decoder dut (
    .clk(clk), .rst(rst), .icode_i(icode), .ra_i(ra), .rb_i(rb), .bch_i(bch),
    .imem_err_i(ie), .dmem_err_i(de), .valc_i(valc), .vala_i(vala),
    .vale_i(vale), .valm_i(valm), .valp_i(valp),
    .src_a_o(sa), .src_b_o(sb), .dst_e_o(dse), .dst_m_o(dsm),
    .mem_rd_o(rd), .mem_wr_o(wr), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .next_pc_o(npc), .status_o(st)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] op, logic [3:0] a, logic [3:0] b,
                       logic br, logic iev, logic dev);
    @(negedge clk);
    icode = op; ra = a; rb = b; bch = br; ie = iev; de = dev;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic exp_regs(string req, logic [3:0] a, logic [3:0] b,
                          logic [3:0] e, logic [3:0] m);
    chk(req, "src_a", 32'(sa), 32'(a));
    chk(req, "src_b", 32'(sb), 32'(b));
    chk(req, "dst_e", 32'(dse), 32'(e));
    chk(req, "dst_m", 32'(dsm), 32'(m));
  endtask

  task automatic exp_mem(string req, logic r, logic w, logic [31:0] ad);
    chk(req, "mem_rd", 32'(rd), 32'(r));
    chk(req, "mem_wr", 32'(wr), 32'(w));
    chk(req, "mem_addr", addr, ad);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_regs("R1", 8, 8, 8, 8);
    exp_mem("R1", 0, 0, 0);
    chk("R1", "wdata", wdata, 0);
    chk("R1", "next_pc", npc, 0);
    chk("R1", "status", 32'(st), 1);
    rst = 1'b0;
  endtask

  task automatic t_rrmov();
    apply(4'h2, 4'd1, 4'd2, 0, 0, 0);
    exp_regs("R2 R4", 1, 8, 2, 8);
    exp_mem("R8", 0, 0, 0);
    chk("R9", "next_pc", npc, VP);
    chk("R10", "status", 32'(st), 1);
  endtask

  task automatic t_irmov();
    apply(4'h3, 4'd3, 4'd6, 0, 0, 0);
    exp_regs("R4", 8, 8, 6, 8);
    exp_mem("R8", 0, 0, 0);
  endtask

  task automatic t_alu();
    apply(4'h6, 4'd3, 4'd5, 0, 0, 0);
    exp_regs("R3", 3, 5, 5, 8);
    exp_mem("R6", 0, 0, 0);
  endtask

  task automatic t_rmmov();
    apply(4'h4, 4'd6, 4'd7, 0, 0, 0);
    exp_regs("R2 R3", 6, 7, 8, 8);
    exp_mem("R7 R8", 0, 1, VE);
    chk("R7", "wdata", wdata, VA);
  endtask

  task automatic t_mrmov();
    apply(4'h5, 4'd1, 4'd2, 0, 0, 0);
    exp_regs("R5", 8, 2, 8, 1);
    exp_mem("R6 R8", 1, 0, VE);
  endtask

  task automatic t_push();
    apply(4'hA, 4'd3, 4'd9, 0, 0, 0);
    exp_regs("R2 R3 R4", 3, 4, 4, 8);
    exp_mem("R7 R8", 0, 1, VE);
    chk("R7", "wdata", wdata, VA);
  endtask

  task automatic t_pop();
    apply(4'hB, 4'd2, 4'd9, 0, 0, 0);
    exp_regs("R2 R5", 4, 4, 4, 2);
    exp_mem("R6 R8", 1, 0, VA);
  endtask

  task automatic t_call();
    apply(4'h8, 4'd0, 4'd0, 0, 0, 0);
    exp_regs("R3 R4", 8, 4, 4, 8);
    exp_mem("R7 R8", 0, 1, VE);
    chk("R7", "wdata", wdata, VP);
    chk("R9", "next_pc", npc, VC);
  endtask

  task automatic t_ret();
    apply(4'h9, 4'd0, 4'd0, 0, 0, 0);
    exp_regs("R2 R4", 4, 4, 4, 8);
    exp_mem("R6 R8", 1, 0, VA);
    chk("R9", "next_pc", npc, VM);
  endtask

  task automatic t_jump();
    apply(4'h7, 4'd0, 4'd0, 1, 0, 0);
    chk("R9", "taken next_pc", npc, VC);
    exp_regs("R4", 8, 8, 8, 8);
    apply(4'h7, 4'd0, 4'd0, 0, 0, 0);
    chk("R9", "fallthru next_pc", npc, VP);
  endtask

  task automatic t_halt_bad();
    apply(4'h0, 4'd0, 4'd0, 0, 0, 0);
    chk("R10", "halt status", 32'(st), 2);
    apply(4'hD, 4'd1, 4'd2, 0, 0, 0);
    chk("R10", "invalid status", 32'(st), 4);
    apply(4'hF, 4'd1, 4'd2, 0, 0, 1);
    chk("R10", "priority status", 32'(st), 3);
  endtask

  task automatic t_dmem_fault();
    apply(4'hA, 4'd3, 4'd0, 0, 0, 1);
    chk("R10", "status", 32'(st), 3);
    chk("R11", "mem_wr", 32'(wr), 0);
    chk("R11", "dst_e", 32'(dse), 8);
    apply(4'hB, 4'd2, 4'd0, 0, 0, 1);
    chk("R11", "pop dst_m", 32'(dsm), 8);
  endtask

  task automatic t_imem_fault();
    apply(4'h8, 4'd1, 4'd2, 1, 1, 0);
    chk("R12", "status", 32'(st), 3);
    exp_regs("R12", 8, 8, 8, 8);
    exp_mem("R12", 0, 0, 0);
    chk("R12", "next_pc", npc, VP);
  endtask

  initial begin
    t_reset();
    t_rrmov();
    t_irmov();
    t_alu();
    t_rmmov();
    t_mrmov();
    t_push();
    t_pop();
    t_call();
    t_ret();
    t_jump();
    t_halt_bad();
    t_dmem_fault();
    t_imem_fault();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule